// File: doc/BRIEF.md
# Sector Unprotect Sequencer

This block is a host-side controller that carries out the in-system procedure for clearing sector protection on a parallel flash device. It masters a simple request/acknowledge bus to the flash and drives an enable for an external high-voltage driver on the device reset pin. A single `start` pulse launches the whole procedure. It raises the high-voltage enable and waits a short setup time. It then issues the entry writes, which are command 0x60 to address 0 followed by command 0x60 to the unprotect address, and waits the long unprotect pulse time.

After the pulse, the sequencer verifies each sector in ascending order. For every sector it writes 0x40 to the sector's verify address and reads the same address back. A read of 0x00 means the sector is unprotected, and the walk moves on. Any other value triggers another unprotect pulse, followed by a fresh verify of the same sector, up to a bounded number of attempts per sector. When the last sector passes, the high-voltage enable drops, a reset command is written and `done` is held. If a sector exhausts its attempts, the enable drops, all bus traffic stops and `fail` is held. Every sector must already be protected before this procedure is run. Wait times count pulses of a one-microsecond tick input.

States: `ST_IDLE`, `ST_SETUP` (setup wait), `ST_WR_ENTER`, `ST_WR_UNPROT`, `ST_PULSE` (long wait), `ST_WR_VERIFY`, `ST_RD_VERIFY`, `ST_JUDGE`, `ST_WR_RESET`, `ST_DONE`, `ST_FAIL`. Transitions:
- `start` moves from idle, done or fail to setup.
- Expiry of the setup wait moves to the entry write.
- Each acknowledged bus access moves to the next step in the order entry write, unprotect write, pulse, verify write, verify read, judge.
- Expiry of the pulse wait moves to the verify write.
- From judge, the sequencer goes to the verify write for the next sector, to the reset write after the last sector, back to the unprotect write for a retry, or to fail.
- The acknowledged reset write moves to done.

Top module: `sector_unprotect_seq`

## Requirements
- R1: After reset, `bus_req`, `hv_reset_en`, `done` and `fail` are all low.
- R2: On `start`, `hv_reset_en` rises. After at least `SETUP_US` ticks, the block writes data 0x60 to address 0, then writes 0x60 to the unprotect address 0x00042 (address bit 6 = 1, bit 1 = 1, bit 0 = 0).
- R3: After the unprotect write is acknowledged, at least `HOLD_US` ticks (default 15000) pass before the next bus access.
- R4: A verify step writes 0x40 to the address with the sector index in bits 19:12 and 0x042 in bits 11:0, then reads that same address. The walk begins at sector 0.
- R5: A verify read of 0x00 advances to the next sector, and that sector's attempt count restarts at 1.
- R6: A nonzero verify read with fewer than `MAX_TRY` attempts made on the sector repeats the unprotect write of 0x60 to 0x00042 and the pulse wait, then verifies the same sector again.
- R7: A nonzero verify read on the `MAX_TRY`-th attempt ends the procedure. `fail` rises, `hv_reset_en` falls, no further bus request is made, and `fail` stays high until the next `start`.
- R8: When sector `NUM_SECT-1` passes, `hv_reset_en` falls first, and then data 0xF0 is written to address 0 with the enable low. `done` then stays high until the next `start`.
- R9: A bus request keeps its address, data and direction unchanged until it is acknowledged.
- R10: A `start` pulse while the procedure is running has no effect.
- R11: `done` and `fail` are never high together, and `hv_reset_en` is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches the procedure |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Flash address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge of the current request |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| hv_reset_en | output | 1 | Enable for the high-voltage level on the flash reset pin |
| done | output | 1 | Procedure completed, held until next start |
| fail | output | 1 | Device failure, held until next start |

## Verification
The verify path is tried with four response patterns from a bench flash model:
- **Every sector passing on its first read.** This pins down the basic transaction order and the timing of the waits.
- **One sector needing three attempts and another needing exactly the attempt limit.** This separates a correct per-sector retry loop with a counter restart from a counter that runs across sectors or stops one attempt early.
- **A sector that never clears.** This shows the failure exit, the stopping of bus traffic and the held flag.
- **A stray `start` in mid-run.** This must leave the transaction stream identical to the clean run.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WR_ENTER,
        ST_WR_UNPROT,
        ST_PULSE,
        ST_WR_VERIFY,
        ST_RD_VERIFY,
        ST_JUDGE,
        ST_WR_RESET,
        ST_DONE,
        ST_FAIL
    } sup_state_e;

    localparam logic [7:0]  CMD_UNPROT = 8'h60;
    localparam logic [7:0]  CMD_VERIFY = 8'h40;
    localparam logic [7:0]  CMD_RESET  = 8'hF0;
    localparam logic [11:0] UNPROT_LOW = 12'h042;
    localparam int          SECT_LSB   = 12;

endpackage

// File: rtl/sup_wait_timer.sv
module sup_wait_timer #(
    parameter int TW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R3: each tick outside a load takes exactly one count off the wait
    a_r3_tick_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R3: without a tick or load the remaining wait is frozen
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/sup_walker.sv
module sup_walker #(
    parameter int NUM_SECT = 35,
    parameter int MAX_TRY  = 1000,
    parameter int SW       = 8,
    parameter int CW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv_sect,
    input  logic          adv_try,
    output logic [SW-1:0] sect,
    output logic [CW-1:0] tries,
    output logic          last_sect,
    output logic          tries_max
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sect  <= '0;
            tries <= CW'(1);
        end else if (adv_sect) begin
            sect  <= sect + 1'b1;
            tries <= CW'(1);
        end else if (adv_try) begin
            tries <= tries + 1'b1;
        end
    end

    assign last_sect = (sect == SW'(NUM_SECT - 1));
    assign tries_max = (tries == CW'(MAX_TRY));

    // R5: moving to a new sector restarts its attempt count at one
    a_r5_try_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_sect && !clr) |=> (tries == CW'(1)));

    // R6: the attempt count never passes its limit
    a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tries >= CW'(1)) && (tries <= CW'(MAX_TRY)));

    // R4: the sector index stays inside the array
    a_r4_sect_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sect <= SW'(NUM_SECT - 1));

endmodule

// File: rtl/sector_unprotect_seq.sv
module sector_unprotect_seq
    import sup_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int NUM_SECT = 35,
    parameter int MAX_TRY  = 1000,
    parameter int SETUP_US = 1,
    parameter int HOLD_US  = 15000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              us_tick,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              hv_reset_en,
    output logic              done,
    output logic              fail
);

    localparam int SW     = ADDR_W - SECT_LSB;
    localparam int CW     = $clog2(MAX_TRY + 1);
    localparam int WAIT_M = (HOLD_US > SETUP_US) ? HOLD_US : SETUP_US;
    localparam int TW     = $clog2(WAIT_M + 1);

    sup_state_e st, nxt;

    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          w_clr, adv_s, adv_t;
    logic [SW-1:0] sect;
    logic [CW-1:0] tries;
    logic          last_sect, tries_max;
    logic [7:0]    rd_q;
    logic [ADDR_W-1:0] sect_addr, unprot_addr;

    sup_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (us_tick),
        .expired  (tmr_done)
    );

    sup_walker #(.NUM_SECT(NUM_SECT), .MAX_TRY(MAX_TRY), .SW(SW), .CW(CW)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (w_clr),
        .adv_sect  (adv_s),
        .adv_try   (adv_t),
        .sect      (sect),
        .tries     (tries),
        .last_sect (last_sect),
        .tries_max (tries_max)
    );

    always_comb begin
        unprot_addr                = '0;
        unprot_addr[SECT_LSB-1:0]  = UNPROT_LOW;
        sect_addr                  = unprot_addr;
        sect_addr[ADDR_W-1:SECT_LSB] = sect;
    end

    // state register and verify data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            rd_q <= '0;
        end else begin
            st <= nxt;
            if (st == ST_RD_VERIFY && bus_ack) rd_q <= bus_rdata;
        end
    end

    // next state and control strobes
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        w_clr    = 1'b0;
        adv_s    = 1'b0;
        adv_t    = 1'b0;
        unique case (st)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) begin
                nxt      = ST_SETUP;
                w_clr    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETUP_US);
            end
            ST_SETUP:     if (tmr_done) nxt = ST_WR_ENTER;
            ST_WR_ENTER:  if (bus_ack)  nxt = ST_WR_UNPROT;
            ST_WR_UNPROT: if (bus_ack) begin
                nxt      = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_US);
            end
            ST_PULSE:     if (tmr_done) nxt = ST_WR_VERIFY;
            ST_WR_VERIFY: if (bus_ack)  nxt = ST_RD_VERIFY;
            ST_RD_VERIFY: if (bus_ack)  nxt = ST_JUDGE;
            ST_JUDGE: begin
                if (rd_q == 8'h00) begin
                    if (last_sect) begin
                        nxt = ST_WR_RESET;
                    end else begin
                        nxt   = ST_WR_VERIFY;
                        adv_s = 1'b1;
                    end
                end else if (tries_max) begin
                    nxt = ST_FAIL;
                end else begin
                    nxt   = ST_WR_UNPROT;
                    adv_t = 1'b1;
                end
            end
            ST_WR_RESET:  if (bus_ack)  nxt = ST_DONE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        bus_req     = 1'b0;
        bus_we      = 1'b1;
        bus_addr    = '0;
        bus_wdata   = '0;
        hv_reset_en = 1'b0;
        done        = 1'b0;
        fail        = 1'b0;
        unique case (st)
            ST_SETUP, ST_PULSE, ST_JUDGE: hv_reset_en = 1'b1;
            ST_WR_ENTER: begin
                hv_reset_en = 1'b1;
                bus_req     = 1'b1;
                bus_wdata   = CMD_UNPROT;
            end
            ST_WR_UNPROT: begin
                hv_reset_en = 1'b1;
                bus_req     = 1'b1;
                bus_addr    = unprot_addr;
                bus_wdata   = CMD_UNPROT;
            end
            ST_WR_VERIFY: begin
                hv_reset_en = 1'b1;
                bus_req     = 1'b1;
                bus_addr    = sect_addr;
                bus_wdata   = CMD_VERIFY;
            end
            ST_RD_VERIFY: begin
                hv_reset_en = 1'b1;
                bus_req     = 1'b1;
                bus_we      = 1'b0;
                bus_addr    = sect_addr;
            end
            ST_WR_RESET: begin
                bus_req   = 1'b1;
                bus_wdata = CMD_RESET;
            end
            ST_DONE: done = 1'b1;
            ST_FAIL: fail = 1'b1;
            default: ;
        endcase
    end

    // R9: a pending request holds still until acknowledged
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_wdata) && $stable(bus_we)));

    // R11: the two end flags exclude each other
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R11: high voltage is off whenever a result is reported
    a_r11_hv_off_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !hv_reset_en);

    // R7: no bus traffic while failure is reported
    a_r7_quiet_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !bus_req);

    // R7: failure holds until a new start
    a_r7_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R8: the reset command only goes out with high voltage removed
    a_r8_reset_cmd_low_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_wdata == CMD_RESET) |-> !hv_reset_en);

endmodule

// File: tb/tb_sector_unprotect_seq.sv
module tb_sector_unprotect_seq;

    localparam int NS    = 35;
    localparam int TRY   = 4;
    localparam int SETUP = 3;
    localparam int HOLD  = 20;
    localparam int LOGN  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        us_tick = 1'b0;
    logic        bus_req, bus_we;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic        hv_reset_en, done, fail;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tick_total = 0;

    int need [NS];
    int att  [NS];
    int stab_err = 0;
    logic pend = 1'b0;
    logic [19:0] h_addr;
    logic [7:0]  h_data;
    logic        h_we;

    int          lg_n = 0;
    logic [19:0] lg_addr [LOGN];
    logic [7:0]  lg_data [LOGN];
    logic        lg_we   [LOGN];
    logic        lg_hv   [LOGN];
    int          lg_tk   [LOGN];

    int          e_n = 0;
    logic [19:0] e_addr [LOGN];
    logic [7:0]  e_data [LOGN];
    logic        e_we   [LOGN];
    logic        e_fail;

    sector_unprotect_seq #(
        .ADDR_W(20), .NUM_SECT(NS), .MAX_TRY(TRY), .SETUP_US(SETUP), .HOLD_US(HOLD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .hv_reset_en(hv_reset_en), .done(done), .fail(fail)
    );

    always #5 clk = ~clk;

    // tick source and flash model, driven between clock edges
    always @(negedge clk) begin
        us_tick = ~us_tick;
        if (us_tick) tick_total++;
        if (!rst_n) begin
            bus_ack = 1'b0;
            pend    = 1'b0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req && !pend) begin
            pend   = 1'b1;
            h_addr = bus_addr;
            h_data = bus_wdata;
            h_we   = bus_we;
        end else if (bus_req && pend) begin
            pend = 1'b0;
            if (h_addr != bus_addr || h_data != bus_wdata || h_we != bus_we) stab_err++;
            bus_ack = 1'b1;
            if (!bus_we) begin
                int s;
                s = int'(bus_addr[19:12]);
                if (s < NS) begin
                    att[s]++;
                    bus_rdata = (att[s] >= need[s]) ? 8'h00 : 8'h01;
                end else begin
                    bus_rdata = 8'hFF;
                end
            end
            if (lg_n < LOGN) begin
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_we ? bus_wdata : 8'h00;
                lg_we[lg_n]   = bus_we;
                lg_hv[lg_n]   = hv_reset_en;
                lg_tk[lg_n]   = tick_total;
            end
            lg_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic push(input logic we, input logic [19:0] a, input logic [7:0] d);
        e_we[e_n] = we; e_addr[e_n] = a; e_data[e_n] = d;
        e_n++;
    endtask

    // expected transaction list built from the requirements
    task automatic build_expected();
        e_n = 0;
        e_fail = 1'b0;
        push(1'b1, 20'h0, 8'h60);
        push(1'b1, 20'h00042, 8'h60);
        for (int s = 0; s < NS && !e_fail; s++) begin
            logic [19:0] sa;
            int t;
            bit passed;
            sa = {8'(s), 12'h042};
            t = 1;
            passed = 1'b0;
            while (!passed && !e_fail) begin
                push(1'b1, sa, 8'h40);
                push(1'b0, sa, 8'h00);
                if (t >= need[s]) passed = 1'b1;
                else if (t == TRY) e_fail = 1'b1;
                else begin
                    t++;
                    push(1'b1, 20'h00042, 8'h60);
                end
            end
        end
        if (!e_fail) push(1'b1, 20'h0, 8'hF0);
    endtask

    task automatic prep(input int slow_sect, input int slow_need,
                        input int lim_sect, input int dead_sect);
        for (int s = 0; s < NS; s++) begin
            need[s] = 1;
            att[s]  = 0;
        end
        if (slow_sect >= 0) need[slow_sect] = slow_need;
        if (lim_sect  >= 0) need[lim_sect]  = TRY;
        if (dead_sect >= 0) need[dead_sect] = 100000;
        lg_n = 0;
        stab_err = 0;
        build_expected();
    endtask

    task automatic run(input bit mid_start, output int tk0);
        @(negedge clk);
        start = 1'b1;
        tk0 = tick_total;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (150) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done || fail)) @(negedge clk);
    endtask

    task automatic compare(input string req);
        int bad;
        bad = -1;
        chk(lg_n == e_n, {req, " transaction count"}, lg_n, e_n);
        for (int i = 0; i < e_n && i < lg_n; i++) begin
            if (bad < 0 && (lg_addr[i] != e_addr[i] || lg_data[i] != e_data[i]
                            || lg_we[i] != e_we[i])) bad = i;
        end
        if (bad >= 0)
            chk(1'b0, {req, " transaction content"}, int'(lg_addr[bad]), int'(e_addr[bad]));
        else
            chk(1'b1, {req, " transaction content"}, 0, 0);
        chk(stab_err == 0, "R9 request held until ack", stab_err, 0);
    endtask

    task automatic t_reset();
        chk(bus_req == 1'b0, "R1 bus_req after reset", bus_req, 0);
        chk(hv_reset_en == 1'b0, "R1 hv after reset", hv_reset_en, 0);
        chk(done == 1'b0 && fail == 1'b0, "R1 flags after reset", {done, fail}, 0);
    endtask

    task automatic t_clean();
        int tk0;
        int hv_bad;
        prep(-1, 0, -1, -1);
        run(1'b0, tk0);
        compare("R4 R5 clean walk");
        chk(lg_tk[0] - tk0 >= SETUP, "R2 setup wait", lg_tk[0] - tk0, SETUP);
        chk(lg_data[0] == 8'h60 && lg_addr[0] == 20'h0, "R2 entry write", int'(lg_data[0]), 'h60);
        chk(lg_tk[2] - lg_tk[1] >= HOLD && lg_tk[2] - lg_tk[1] <= HOLD + 3,
            "R3 pulse wait", lg_tk[2] - lg_tk[1], HOLD);
        hv_bad = 0;
        for (int i = 0; i < lg_n - 1; i++) if (!lg_hv[i]) hv_bad++;
        chk(hv_bad == 0, "R2 hv high during walk", hv_bad, 0);
        chk(lg_hv[lg_n-1] == 1'b0 && lg_data[lg_n-1] == 8'hF0, "R8 reset cmd with hv low",
            int'(lg_hv[lg_n-1]), 0);
        chk(done == 1'b1 && fail == 1'b0, "R8 done reported", {done, fail}, 2);
        repeat (40) @(negedge clk);
        chk(done == 1'b1 && !hv_reset_en && !bus_req, "R8 done held", done, 1);
        chk(!(done && fail), "R11 flags exclusive", {done, fail}, 2);
    endtask

    task automatic t_retry();
        int tk0;
        prep(5, 3, 7, -1);
        run(1'b0, tk0);
        compare("R6 retry and limit-pass");
        chk(att[5] == 3, "R6 sector 5 attempts", att[5], 3);
        chk(att[7] == TRY, "R5 sector 7 fresh count reaches limit", att[7], TRY);
        chk(done == 1'b1 && fail == 1'b0, "R6 done after retries", {done, fail}, 2);
    endtask

    task automatic t_fail();
        int tk0;
        int n_at_fail;
        prep(-1, 0, -1, 3);
        run(1'b0, tk0);
        compare("R7 dead sector");
        chk(fail == 1'b1 && done == 1'b0, "R7 fail reported", {done, fail}, 1);
        chk(hv_reset_en == 1'b0, "R7 hv dropped", hv_reset_en, 0);
        chk(att[3] == TRY, "R7 attempts on dead sector", att[3], TRY);
        n_at_fail = lg_n;
        repeat (60) @(negedge clk);
        chk(fail == 1'b1, "R7 fail held", fail, 1);
        chk(lg_n == n_at_fail && !bus_req, "R7 no traffic after fail", lg_n, n_at_fail);
    endtask

    task automatic t_mid_start();
        int tk0;
        prep(-1, 0, -1, -1);
        run(1'b1, tk0);
        compare("R10 start while running");
        chk(done == 1'b1 && fail == 1'b0, "R10 clears fail and completes", {done, fail}, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_clean();
        t_retry();
        t_fail();
        t_mid_start();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule